// File: doc/BRIEF.md
# Half-Select Wide Multiplier

This block multiplies one 128-bit half of a 256-bit source by one 128-bit half of a second 256-bit source. A 2-bit selector picks which halves pair up, and the 256-bit product always fits, so no overflow handling is needed. Alongside the product the block reports three condition flags: the top bit, the bottom bit, and whether the product is zero. It also raises write enables for those three flags and holds the carry write enable low, so the carry flag is never changed.

The work is iterative. Each operand half is split into 32-bit digits, and one digit-by-digit partial product is added into a 256-bit accumulator each cycle. With the default widths a result takes a fixed sixteen steps. A caller raises `start` while the unit is idle, waits for the one-cycle `done` pulse, and can then read the product and flags. Both stay unchanged until the next start is accepted.

Top module: `halfmul_unit`

## Requirements
- R1: With `sel` = 2'b00 the product is src0[127:0] × src1[127:0].
- R2: With `sel` = 2'b01 the product is src1[127:0] × src0[255:128].
- R3: With `sel` = 2'b10 the product is src1[255:128] × src0[127:0].
- R4: With `sel` = 2'b11 the product is src0[255:128] × src1[255:128].
- R5: `flag_m` equals product bit 255, `flag_l` equals product bit 0, and `flag_z` is 1 exactly when the product is zero.
- R6: `wr_m`, `wr_l` and `wr_z` are high only in the cycle `done` is high. `wr_c` is always 0.
- R7: `done` is a single-cycle pulse. It rises exactly (HALF_W/DIGIT_W)² clock edges after the edge that accepted `start` (16 with defaults).
- R8: `busy` is high from the edge after acceptance until `done` rises. A `start` raised while `busy` is high is ignored: the result and the latency of the running operation are unchanged.
- R9: After `done`, the product and flags hold their values until the next accepted `start`.
- R10: After reset `busy` and `done` are 0, the product is 0 and `flag_z` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; taken only when idle |
| sel | input | 2 | Half pairing selector |
| src0 | input | 256 | First source operand |
| src1 | input | 256 | Second source operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 256 | Accumulated product |
| flag_m | output | 1 | Product bit 255 |
| flag_l | output | 1 | Product bit 0 |
| flag_z | output | 1 | Product is zero |
| wr_c | output | 1 | Carry flag write enable, held low |
| wr_m | output | 1 | Top-bit flag write enable |
| wr_l | output | 1 | Bottom-bit flag write enable |
| wr_z | output | 1 | Zero flag write enable |

## Verification
A wrong digit index or shift amount corrupts the product in specific bit ranges. Random operands expose this in the product read at the `done` pulse, about sixteen cycles after the start. A wrong half pairing in a mixed selector mode gives the wrong value in that same cycle. A miscounted step counter moves `done` away from edge sixteen. A start that leaks in while busy clears the accumulator, which shows up as a wrong product or a late `done` in the operation already running.

// File: rtl/halfmul_unit.sv
module halfmul_unit #(
  parameter int HALF_W  = 128,
  parameter int DIGIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        sel,
  input  logic [2*HALF_W-1:0] src0,
  input  logic [2*HALF_W-1:0] src1,
  output logic              busy,
  output logic              done,
  output logic [2*HALF_W-1:0] product,
  output logic              flag_m,
  output logic              flag_l,
  output logic              flag_z,
  output logic              wr_c,
  output logic              wr_m,
  output logic              wr_l,
  output logic              wr_z
);
  localparam int PROD_W = 2 * HALF_W;
  localparam int DIGITS = HALF_W / DIGIT_W;
  localparam int STEPS  = DIGITS * DIGITS;
  localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic [HALF_W-1:0]  lo0, hi0, lo1, hi1, op_a, op_b, a_q, b_q;
  logic [IDX_W-1:0]   di, dj;
  logic [DIGIT_W-1:0] da, db;
  logic [2*DIGIT_W-1:0] pp;
  logic [PROD_W-1:0]  pp_sh, acc;
  logic               last, accept;

  assign lo0 = src0[HALF_W-1:0];
  assign hi0 = src0[PROD_W-1:HALF_W];
  assign lo1 = src1[HALF_W-1:0];
  assign hi1 = src1[PROD_W-1:HALF_W];

  always_comb begin
    case (sel)
      2'b00:   begin op_a = lo0; op_b = lo1; end
      2'b01:   begin op_a = lo1; op_b = hi0; end
      2'b10:   begin op_a = hi1; op_b = lo0; end
      default: begin op_a = hi0; op_b = hi1; end
    endcase
  end

  assign accept = start && !busy;
  assign da     = DIGIT_W'(a_q >> (DIGIT_W * int'(di)));
  assign db     = DIGIT_W'(b_q >> (DIGIT_W * int'(dj)));
  assign pp     = da * db;
  assign pp_sh  = PROD_W'(pp) << (DIGIT_W * (int'(di) + int'(dj)));
  assign last   = (di == IDX_W'(DIGITS - 1)) && (dj == IDX_W'(DIGITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      acc  <= '0;
      di   <= '0;
      dj   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        a_q  <= op_a;
        b_q  <= op_b;
        acc  <= '0;
        di   <= '0;
        dj   <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= acc + pp_sh;
        if (dj == IDX_W'(DIGITS - 1)) begin
          dj <= '0;
          di <= di + 1'b1;
        end else begin
          dj <= dj + 1'b1;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = acc;
  assign flag_m  = acc[PROD_W-1];
  assign flag_l  = acc[0];
  assign flag_z  = (acc == '0);
  assign wr_c    = 1'b0;
  assign wr_m    = done;
  assign wr_l    = done;
  assign wr_z    = done;

  int lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_cnt <= 0;
    else if (accept) lat_cnt <= 0;
    else if (busy)   lat_cnt <= lat_cnt + 1;
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == STEPS));

  // R7
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/halfmul_unit_tb.sv
module halfmul_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [255:0] src0 = '0, src1 = '0;
  logic busy, done, flag_m, flag_l, flag_z, wr_c, wr_m, wr_l, wr_z;
  logic [255:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  halfmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel),
    .src0(src0), .src1(src1), .busy(busy), .done(done),
    .product(product), .flag_m(flag_m), .flag_l(flag_l), .flag_z(flag_z),
    .wr_c(wr_c), .wr_m(wr_m), .wr_l(wr_l), .wr_z(wr_z)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] ref_mul(input logic [1:0] s,
                                           input logic [255:0] x,
                                           input logic [255:0] y);
    logic [255:0] a, b;
    case (s)
      2'b00: begin a = {128'b0, x[127:0]};   b = {128'b0, y[127:0]};   end
      2'b01: begin a = {128'b0, y[127:0]};   b = {128'b0, x[255:128]}; end
      2'b10: begin a = {128'b0, y[255:128]}; b = {128'b0, x[127:0]};   end
      default: begin a = {128'b0, x[255:128]}; b = {128'b0, y[255:128]}; end
    endcase
    return a * b;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run(input logic [1:0] s, input logic [255:0] x,
                     input logic [255:0] y, input bit poke);
    logic [255:0] exp;
    int n;
    string rq;
    exp = ref_mul(s, x, y);
    rq = (s == 2'b00) ? "R1" : (s == 2'b01) ? "R2" : (s == 2'b10) ? "R3" : "R4";
    @(negedge clk);
    start = 1'b1; sel = s; src0 = x; src1 = y;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    src0 = rnd256(); src1 = rnd256(); sel = ~s;
    chk(busy === 1'b1, "R8 busy after accept", 256'(busy), 256'(1));
    n = 0;
    while (n < 40) begin
      if (poke && n == 5) start = 1'b1;
      if (poke && n == 7) start = 1'b0;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
    end
    start = 1'b0;
    chk(n == STEPS, "R7 latency", 256'(n), 256'(STEPS));
    chk(product === exp, poke ? "R8 start ignored while busy" : rq, product, exp);
    chk({flag_m, flag_l, flag_z} === {exp[255], exp[0], exp == 0}, "R5 flags",
        256'({flag_m, flag_l, flag_z}), 256'({exp[255], exp[0], exp == 0}));
    chk({wr_c, wr_m, wr_l, wr_z} === 4'b0111, "R6 write enables at done",
        256'({wr_c, wr_m, wr_l, wr_z}), 256'(4'b0111));
    chk(busy === 1'b0, "R8 busy low at done", 256'(busy), 256'(0));
    @(negedge clk);
    chk(done === 1'b0, "R7 done single pulse", 256'(done), 256'(0));
    chk({wr_c, wr_m, wr_l, wr_z} === 4'b0000, "R6 enables low after done",
        256'({wr_c, wr_m, wr_l, wr_z}), 256'(0));
    repeat (2) @(negedge clk);
    chk(product === exp, "R9 product held", product, exp);
  endtask

  initial begin
    logic [255:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 control after reset",
        256'({busy, done}), 256'(0));
    chk(product === '0 && flag_z === 1'b1, "R10 product after reset",
        product, 256'(0));
    for (int s = 0; s < 4; s++) begin
      run(2'(s), '0, '0, 1'b0);
      run(2'(s), ones, ones, 1'b0);
      run(2'(s), {128'd3, 128'd5}, {128'd7, 128'd11}, 1'b0);
      run(2'(s), ones, '0, 1'b0);
      for (int k = 0; k < 6; k++) run(2'(s), rnd256(), rnd256(), 1'b0);
      for (int b = 0; b < 256; b += 37)
        run(2'(s), 256'(1) << b, ones >> (b % 128), 1'b0);
      run(2'(s), rnd256(), rnd256(), 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule